// File: doc/BRIEF.md
# Ownership-Tracking Store Buffer

This block sits between a core's store port and a coherent data cache. A store retires from the core as soon as a free slot can take it. The buffer then asks the coherence controller for exclusive ownership of that store's cache line, without waiting for anything else. A slot cannot write into the cache until the controller reports that its line is held in an exclusive or modified state. Once the cache accepts the write, the slot is released for a new store.

Slots are written to the cache strictly in the order the stores arrived. A slot whose grant comes early still waits behind older slots. Loads probe the buffer combinationally. When a load matches a buffered word, it gets the data of the youngest matching store instead of reading the cache. A barrier input stops new stores from entering, and a done output tells the core when the buffer has emptied.

Top module: `own_store_buffer`

## Requirements
- R1: `st_ready` is low whenever all DEPTH slots are occupied. A store offered while `st_ready` is low is not taken, and no cache write ever appears for it.
- R2: Each accepted store produces exactly one ownership request. Requests go out oldest slot first. `own_req_line` carries the store address shifted right by log2(LINE_BYTES), and `own_req_tag` carries the slot index. Slots are filled in ring order from index 0 after reset. With no older request pending, the request is valid in the cycle after acceptance.
- R3: No cache write is presented for a slot before a grant (`own_gnt_valid` with a matching `own_gnt_tag`) has arrived after that slot's request. Once the grant arrives, the write is presented in the next cycle if the slot is the oldest.
- R4: Cache writes leave in acceptance order. A grant for a younger slot does not let that slot write ahead of an older slot that has not yet been granted.
- R5: Each cache write carries the store's word-aligned address (low log2(DATA_W/8) bits zero), its data and its byte enables. The write holds steady while `wr_ready` is low. The slot is freed on the handshake.
- R6: A load whose word address (address bits above the byte-in-word bits) matches a buffered store sees `ld_hit`=1, with `ld_data`/`ld_be` taken from the youngest such store. The match is visible from the cycle after that store is accepted. With no match, `ld_hit`=0.
- R7: While `barrier` is high, `st_ready` is low. `barrier_done` is high exactly when no slot is occupied, so it rises only after the last write handshake.
- R8: After reset the buffer is empty: `st_ready`=1 (barrier low), `barrier_done`=1, and no request, write or load hit is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Core offers a store |
| st_ready | output | 1 | A slot is free and no barrier is active |
| st_addr | input | ADDR_W | Store byte address |
| st_data | input | DATA_W | Store data word |
| st_be | input | DATA_W/8 | Store byte enables |
| own_req_valid | output | 1 | Ownership request pending |
| own_req_ready | input | 1 | Coherence controller takes the request |
| own_req_line | output | LINE_W | Line address of the request |
| own_req_tag | output | IDX_W | Slot index that the request belongs to |
| own_gnt_valid | input | 1 | Line is now held exclusive or modified |
| own_gnt_tag | input | IDX_W | Slot index of the grant |
| wr_valid | output | 1 | Oldest slot is ready to write |
| wr_ready | input | 1 | Cache accepts the write |
| wr_addr | output | ADDR_W | Word-aligned write address |
| wr_data | output | DATA_W | Write data |
| wr_be | output | DATA_W/8 | Write byte enables |
| ld_addr | input | ADDR_W | Load probe address |
| ld_hit | output | 1 | Probe matches a buffered store |
| ld_data | output | DATA_W | Forwarded data |
| ld_be | output | DATA_W/8 | Bytes valid in the forwarded data |
| barrier | input | 1 | Barrier: block stores and drain |
| barrier_done | output | 1 | Buffer is empty |

## Verification
A store accepted at a rising edge becomes visible after one edge: its request and its forwarding match both appear in the cycle that follows. A grant applied at an edge produces the write one cycle later, provided the slot is the oldest. `st_ready` and `barrier_done` follow the occupancy and `barrier` with no delay. The bench drives all inputs on the falling edge and samples every output 1 ns later. A single monitor therefore sees each handshake one half-cycle before the rising edge that completes it, and each directed check is placed in the exact cycle given by this timing. Expected writes are queued when each store handshake is seen. They are popped on each write handshake, and grants are issued out of order to test the ordering rule.

// File: rtl/sb_pkg.sv
package sb_pkg;

    // Default geometry of the buffer
    localparam int unsigned SB_ADDR_W     = 32;
    localparam int unsigned SB_DATA_W     = 32;
    localparam int unsigned SB_LINE_BYTES = 64;
    localparam int unsigned SB_DEPTH      = 4;

    // Life cycle of one slot: free, waiting to send its request,
    // waiting for exclusive ownership, owned and allowed to write.
    typedef enum logic [1:0] {
        SLOT_FREE     = 2'd0,
        SLOT_NEED_REQ = 2'd1,
        SLOT_WAIT_OWN = 2'd2,
        SLOT_OWNED    = 2'd3
    } slot_phase_e;

endpackage

// File: rtl/sb_ring_pick.sv
// Picks the first set bit of a mask in ring order starting at origin,
// walking either forward (oldest first) or backward (youngest first).
// DEPTH must be a power of two of at least 2.
module sb_ring_pick #(
    parameter int unsigned DEPTH    = 4,
    parameter bit          YOUNGEST = 1'b0,
    localparam int unsigned IDX_W   = $clog2(DEPTH)
) (
    input  logic [IDX_W-1:0] origin,
    input  logic [DEPTH-1:0] mask,
    output logic             found,
    output logic [IDX_W-1:0] idx
);

    logic [IDX_W-1:0] order [DEPTH];

    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_order
            if (YOUNGEST) begin : g_back
                assign order[g] = origin - IDX_W'(g);
            end else begin : g_fwd
                assign order[g] = origin + IDX_W'(g);
            end
        end
    endgenerate

    // Scan from the farthest position so the nearest hit wins.
    always_comb begin
        found = 1'b0;
        idx   = origin;
        for (int k = DEPTH - 1; k >= 0; k--) begin
            if (mask[order[k]]) begin
                found = 1'b1;
                idx   = order[k];
            end
        end
    end

endmodule

// File: rtl/sb_fwd.sv
// Load probe: compares a word address against every live slot and
// returns the youngest match.
module sb_fwd #(
    parameter int unsigned DEPTH  = 4,
    parameter int unsigned WORD_W = 30,
    localparam int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic [WORD_W-1:0]             probe,
    input  logic [DEPTH-1:0][WORD_W-1:0]  words,
    input  logic [DEPTH-1:0]              live,
    input  logic [IDX_W-1:0]              newest,
    output logic                          hit,
    output logic [IDX_W-1:0]              idx
);

    logic [DEPTH-1:0] match;

    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_cmp
            assign match[g] = live[g] && (words[g] == probe);
        end
    endgenerate

    sb_ring_pick #(
        .DEPTH    (DEPTH),
        .YOUNGEST (1'b1)
    ) u_pick (
        .origin (newest),
        .mask   (match),
        .found  (hit),
        .idx    (idx)
    );

endmodule

// File: rtl/own_store_buffer.sv
module own_store_buffer
    import sb_pkg::*;
#(
    parameter int unsigned ADDR_W     = SB_ADDR_W,
    parameter int unsigned DATA_W     = SB_DATA_W,
    parameter int unsigned LINE_BYTES = SB_LINE_BYTES,
    parameter int unsigned DEPTH      = SB_DEPTH,
    localparam int unsigned BE_W      = DATA_W / 8,
    localparam int unsigned WORD_OFF  = $clog2(BE_W),
    localparam int unsigned LINE_OFF  = $clog2(LINE_BYTES),
    localparam int unsigned OFS_W     = LINE_OFF - WORD_OFF,
    localparam int unsigned LINE_W    = ADDR_W - LINE_OFF,
    localparam int unsigned WORD_W    = ADDR_W - WORD_OFF,
    localparam int unsigned IDX_W     = $clog2(DEPTH),
    localparam int unsigned CNT_W     = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              st_valid,
    output logic              st_ready,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [DATA_W-1:0] st_data,
    input  logic [BE_W-1:0]   st_be,
    output logic              own_req_valid,
    input  logic              own_req_ready,
    output logic [LINE_W-1:0] own_req_line,
    output logic [IDX_W-1:0]  own_req_tag,
    input  logic              own_gnt_valid,
    input  logic [IDX_W-1:0]  own_gnt_tag,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic [BE_W-1:0]   wr_be,
    input  logic [ADDR_W-1:0] ld_addr,
    output logic              ld_hit,
    output logic [DATA_W-1:0] ld_data,
    output logic [BE_W-1:0]   ld_be,
    input  logic              barrier,
    output logic              barrier_done
);

    typedef struct packed {
        slot_phase_e       phase;
        logic [LINE_W-1:0] line;
        logic [OFS_W-1:0]  ofs;
        logic [DATA_W-1:0] data;
        logic [BE_W-1:0]   be;
    } slot_t;

    slot_t            slots [DEPTH];
    logic [IDX_W-1:0] head;
    logic [IDX_W-1:0] tail;
    logic [CNT_W-1:0] occ;

    logic push;
    logic pop;
    logic req_fire;

    // Byte-in-word bits take no part in matching or addressing.
    logic unused_low_bits;
    assign unused_low_bits = ^{st_addr[WORD_OFF-1:0], ld_addr[WORD_OFF-1:0]};

    // ---------------- core side ----------------
    assign st_ready     = (occ != CNT_W'(DEPTH)) && !barrier;
    assign push         = st_valid && st_ready;
    assign barrier_done = (occ == '0);

    // ---------------- ownership requests ----------------
    logic [DEPTH-1:0] need_req;
    logic [IDX_W-1:0] req_idx;

    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_need
            assign need_req[g] = (slots[g].phase == SLOT_NEED_REQ);
        end
    endgenerate

    sb_ring_pick #(
        .DEPTH    (DEPTH),
        .YOUNGEST (1'b0)
    ) u_req_pick (
        .origin (head),
        .mask   (need_req),
        .found  (own_req_valid),
        .idx    (req_idx)
    );

    assign own_req_line = slots[req_idx].line;
    assign own_req_tag  = req_idx;
    assign req_fire     = own_req_valid && own_req_ready;

    // ---------------- in-order drain ----------------
    assign wr_valid = (slots[head].phase == SLOT_OWNED);
    assign wr_addr  = {slots[head].line, slots[head].ofs, {WORD_OFF{1'b0}}};
    assign wr_data  = slots[head].data;
    assign wr_be    = slots[head].be;
    assign pop      = wr_valid && wr_ready;

    // ---------------- load forwarding ----------------
    logic [DEPTH-1:0][WORD_W-1:0] slot_words;
    logic [DEPTH-1:0]             slot_live;
    logic [IDX_W-1:0]             fwd_idx;
    logic                         fwd_hit;

    generate
        for (g = 0; g < DEPTH; g++) begin : g_words
            assign slot_words[g] = {slots[g].line, slots[g].ofs};
            assign slot_live[g]  = (slots[g].phase != SLOT_FREE);
        end
    endgenerate

    sb_fwd #(
        .DEPTH  (DEPTH),
        .WORD_W (WORD_W)
    ) u_fwd (
        .probe  (ld_addr[ADDR_W-1:WORD_OFF]),
        .words  (slot_words),
        .live   (slot_live),
        .newest (tail - IDX_W'(1)),
        .hit    (fwd_hit),
        .idx    (fwd_idx)
    );

    assign ld_hit  = fwd_hit;
    assign ld_data = fwd_hit ? slots[fwd_idx].data : '0;
    assign ld_be   = fwd_hit ? slots[fwd_idx].be   : '0;

    // ---------------- state ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                slots[i] <= '{phase: SLOT_FREE, default: '0};
            end
            head <= '0;
            tail <= '0;
            occ  <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (push && (tail == IDX_W'(i))) begin
                    slots[i] <= '{phase: SLOT_NEED_REQ,
                                  line:  st_addr[ADDR_W-1:LINE_OFF],
                                  ofs:   st_addr[LINE_OFF-1:WORD_OFF],
                                  data:  st_data,
                                  be:    st_be};
                end else if (pop && (head == IDX_W'(i))) begin
                    slots[i].phase <= SLOT_FREE;
                end else if (own_gnt_valid && (own_gnt_tag == IDX_W'(i))
                             && (slots[i].phase == SLOT_WAIT_OWN)) begin
                    slots[i].phase <= SLOT_OWNED;
                end else if (req_fire && (req_idx == IDX_W'(i))) begin
                    slots[i].phase <= SLOT_WAIT_OWN;
                end
            end
            if (push) tail <= tail + IDX_W'(1);
            if (pop)  head <= head + IDX_W'(1);
            occ <= occ + CNT_W'(push) - CNT_W'(pop);
        end
    end

endmodule

// File: rtl/sb_checker.sv
module sb_checker #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned LINE_W = 26,
    parameter int unsigned IDX_W  = 2,
    parameter int unsigned CNT_W  = 3,
    parameter int unsigned DEPTH  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              st_ready,
    input logic              own_req_valid,
    input logic              own_req_ready,
    input logic [LINE_W-1:0] own_req_line,
    input logic [IDX_W-1:0]  own_req_tag,
    input logic              wr_valid,
    input logic              wr_ready,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W/8-1:0] wr_be,
    input logic              ld_hit,
    input logic              barrier,
    input logic              barrier_done,
    input logic [CNT_W-1:0]  occ
);

    p_full_stall_r1: assert property (@(posedge clk) disable iff (rst)
        (occ == CNT_W'(DEPTH)) |-> !st_ready);

    p_req_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (own_req_valid && !own_req_ready) |=>
            (own_req_valid && $stable(own_req_tag) && $stable(own_req_line)));

    p_wr_nonempty_r3: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> (occ != '0));

    p_wr_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !wr_ready) |=>
            (wr_valid && $stable(wr_addr) && $stable(wr_data) && $stable(wr_be)));

    p_barrier_stall_r7: assert property (@(posedge clk) disable iff (rst)
        barrier |-> !st_ready);

    p_done_idle_r7: assert property (@(posedge clk) disable iff (rst)
        barrier_done |-> (!wr_valid && !own_req_valid && !ld_hit));

endmodule

bind own_store_buffer sb_checker #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .LINE_W (LINE_W),
    .IDX_W  (IDX_W),
    .CNT_W  (CNT_W),
    .DEPTH  (DEPTH)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .st_ready      (st_ready),
    .own_req_valid (own_req_valid),
    .own_req_ready (own_req_ready),
    .own_req_line  (own_req_line),
    .own_req_tag   (own_req_tag),
    .wr_valid      (wr_valid),
    .wr_ready      (wr_ready),
    .wr_addr       (wr_addr),
    .wr_data       (wr_data),
    .wr_be         (wr_be),
    .ld_hit        (ld_hit),
    .barrier       (barrier),
    .barrier_done  (barrier_done),
    .occ           (occ)
);

// File: tb/sim_own_store_buffer.sv
`timescale 1ns/1ps
module sim_own_store_buffer;

    localparam int DEPTH = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        st_valid = 1'b0;
    logic        st_ready;
    logic [31:0] st_addr = '0;
    logic [31:0] st_data = '0;
    logic [3:0]  st_be = '0;
    logic        own_req_valid;
    logic        own_req_ready = 1'b0;
    logic [25:0] own_req_line;
    logic [1:0]  own_req_tag;
    logic        own_gnt_valid = 1'b0;
    logic [1:0]  own_gnt_tag = '0;
    logic        wr_valid;
    logic        wr_ready = 1'b0;
    logic [31:0] wr_addr;
    logic [31:0] wr_data;
    logic [3:0]  wr_be;
    logic [31:0] ld_addr = '0;
    logic        ld_hit;
    logic [31:0] ld_data;
    logic [3:0]  ld_be;
    logic        barrier = 1'b0;
    logic        barrier_done;

    always #2 clk = ~clk;

    own_store_buffer u0 (.*);

    typedef struct {
        logic [31:0] a;
        logic [31:0] d;
        logic [3:0]  b;
    } wr_item_t;

    wr_item_t   exp_q[$];
    logic [1:0] req_q[$];
    int checks = 0;
    int errors = 0;
    bit auto_grant = 1'b0;
    bit bp_en = 1'b0;

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Monitor: samples 1 ns after each falling edge, one half-cycle before
    // the rising edge that completes any handshake it sees.
    initial forever begin
        @(negedge clk);
        #1;
        if (!rst) begin
            if (st_valid && st_ready)
                exp_q.push_back('{a: st_addr & 32'hFFFF_FFFC, d: st_data, b: st_be});
            if (own_req_valid && own_req_ready)
                req_q.push_back(own_req_tag);
            if (wr_valid && wr_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R1", "unexpected write", {32'h0, wr_addr}, 64'h0);
                end else begin
                    wr_item_t e;
                    e = exp_q.pop_front();
                    chk(wr_addr == e.a && wr_data == e.d, "R4/R5", "write addr/data",
                        {wr_addr, wr_data}, {e.a, e.d});
                    chk(wr_be == e.b, "R5", "write byte enables", 64'(wr_be), 64'(e.b));
                end
            end
        end
    end

    // Grant source: grants requests in arrival order when enabled
    initial forever begin
        @(negedge clk);
        if (auto_grant) begin
            if (req_q.size() > 0) begin
                own_gnt_valid = 1'b1;
                own_gnt_tag   = req_q.pop_front();
            end else begin
                own_gnt_valid = 1'b0;
            end
        end
        if (bp_en) begin
            wr_ready      = ($urandom % 2) == 0;
            own_req_ready = ($urandom % 3) != 0;
        end
    end

    initial begin
        #(4 * 100000);
        chk(1'b0, "R5", "watchdog expired", 64'h0, 64'h1);
        finish_run();
    end

    task automatic put_store(input logic [31:0] a, input logic [31:0] d, input logic [3:0] b);
        @(negedge clk);
        st_valid = 1'b1;
        st_addr  = a;
        st_data  = d;
        st_be    = b;
        #1;
        while (!st_ready) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        st_valid = 1'b0;
    endtask

    task automatic grant(input logic [1:0] t);
        @(negedge clk);
        own_gnt_valid = 1'b1;
        own_gnt_tag   = t;
        @(negedge clk);
        own_gnt_valid = 1'b0;
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        cycles(3);
        rst = 1'b0;
        @(negedge clk);
        #1;
        // R8: reset state
        chk(st_ready == 1'b1, "R8", "st_ready after reset", 64'(st_ready), 64'h1);
        chk(barrier_done == 1'b1, "R8", "barrier_done after reset", 64'(barrier_done), 64'h1);
        chk(!own_req_valid && !wr_valid && !ld_hit, "R8", "idle outputs after reset",
            {61'h0, own_req_valid, wr_valid, ld_hit}, 64'h0);

        own_req_ready = 1'b1;
        wr_ready      = 1'b1;

        // R2: request for the first store, slot 0, line = addr >> 6
        put_store(32'h0000_1000, 32'h1111_1111, 4'hF);
        #1;
        chk(own_req_valid == 1'b1, "R2", "request valid after accept", 64'(own_req_valid), 64'h1);
        chk(own_req_line == 26'h40, "R2", "request line", 64'(own_req_line), 64'h40);
        chk(own_req_tag == 2'd0, "R2", "request tag", 64'(own_req_tag), 64'h0);

        put_store(32'h0000_2004, 32'h2222_2222, 4'h3);
        put_store(32'h0000_1000, 32'h3333_3333, 4'hC);
        #1;
        // R6: youngest match wins; other word hits; unrelated word misses
        ld_addr = 32'h0000_1002;
        #0.1;
        chk(ld_hit && ld_data == 32'h3333_3333, "R6", "youngest forward data",
            64'(ld_data), 64'h3333_3333);
        chk(ld_be == 4'hC, "R6", "youngest forward be", 64'(ld_be), 64'hC);
        ld_addr = 32'h0000_2004;
        #0.1;
        chk(ld_hit && ld_data == 32'h2222_2222, "R6", "second word forward",
            64'(ld_data), 64'h2222_2222);
        ld_addr = 32'h0000_3000;
        #0.1;
        chk(ld_hit == 1'b0, "R6", "no match miss", 64'(ld_hit), 64'h0);

        cycles(3);
        #1;
        chk(req_q.size() == 3, "R2", "one request per store", 64'(req_q.size()), 64'h3);
        chk(wr_valid == 1'b0, "R3", "no write before grant", 64'(wr_valid), 64'h0);

        // R4: younger grants first must not drain
        grant(req_q[1]);
        #1;
        chk(wr_valid == 1'b0, "R4", "younger grant waits", 64'(wr_valid), 64'h0);
        grant(req_q[2]);
        #1;
        chk(wr_valid == 1'b0, "R4", "youngest grant waits", 64'(wr_valid), 64'h0);
        grant(req_q[0]);
        #1;
        chk(wr_valid == 1'b1, "R3", "write one cycle after grant", 64'(wr_valid), 64'h1);
        chk(wr_addr == 32'h0000_1000, "R3", "oldest drains first", 64'(wr_addr), 64'h1000);
        cycles(5);
        #1;
        chk(exp_q.size() == 0, "R5", "all writes drained", 64'(exp_q.size()), 64'h0);
        chk(barrier_done == 1'b1, "R7", "done when empty", 64'(barrier_done), 64'h1);
        req_q.delete();

        // R1: fill every slot with grants withheld
        for (int i = 0; i < DEPTH; i++)
            put_store(32'h0000_4000 + 32'(i * 64), 32'hA000_0000 + 32'(i), 4'hF);
        #1;
        chk(st_ready == 1'b0, "R1", "ready low when full", 64'(st_ready), 64'h0);
        @(negedge clk);
        st_valid = 1'b1;
        st_addr  = 32'h0000_9000;
        st_data  = 32'hDEAD_BEEF;
        st_be    = 4'hF;
        cycles(2);
        st_valid = 1'b0;
        #1;
        chk(exp_q.size() == DEPTH, "R1", "store refused when full", 64'(exp_q.size()), 64'(DEPTH));

        // R7: barrier blocks stores and drains everything
        @(negedge clk);
        barrier = 1'b1;
        #1;
        chk(st_ready == 1'b0, "R7", "ready low under barrier", 64'(st_ready), 64'h0);
        chk(barrier_done == 1'b0, "R7", "done low while occupied", 64'(barrier_done), 64'h1 - 64'h1);
        auto_grant = 1'b1;
        for (int i = 0; i < 200 && !barrier_done; i++) begin
            @(negedge clk);
            #1;
        end
        chk(barrier_done == 1'b1, "R7", "barrier drain completes", 64'(barrier_done), 64'h1);
        chk(exp_q.size() == 0, "R7", "done only after last write", 64'(exp_q.size()), 64'h0);
        chk(st_ready == 1'b0, "R7", "still blocked while barrier high", 64'(st_ready), 64'h0);
        ld_addr = 32'h0000_4000;
        #0.1;
        chk(ld_hit == 1'b0, "R6", "no forward after drain", 64'(ld_hit), 64'h0);
        @(negedge clk);
        barrier = 1'b0;
        #1;
        chk(st_ready == 1'b1, "R7", "ready back after barrier", 64'(st_ready), 64'h1);

        // R5: stream with random back-pressure on both handshakes
        bp_en = 1'b1;
        for (int i = 0; i < 24; i++)
            put_store(32'h0001_0000 + 32'((i % 7) * 36), 32'h5000_0000 + 32'(i * 3),
                      4'(1 + (i % 15)));
        for (int i = 0; i < 400 && exp_q.size() != 0; i++) @(negedge clk);
        bp_en    = 1'b0;
        wr_ready = 1'b1;
        cycles(4);
        #1;
        chk(exp_q.size() == 0, "R5", "stream fully drained", 64'(exp_q.size()), 64'h0);
        chk(barrier_done == 1'b1, "R7", "empty after stream", 64'(barrier_done), 64'h1);

        finish_run();
    end

endmodule